// File: doc/BRIEF.md
# Retentive Set/Reset Memory Cell

This block holds a single bit of control state that behaves like a magnetically latched relay. The bit keeps its value when power goes away. Logic sources close the cell through any of several set inputs and open it through any of several clear inputs. Both of those paths act only while a shared arm line is high, so one signal can freeze the cell against all of its logic drivers at once. Two manual strobes, one to force the cell closed and one to force it open, sit beside the logic path. They work even when the cell is disarmed, for instance from a maintenance probe.

The stored bit sits in a register that the system reset never clears. While reset is high the cell ignores every input and keeps its value, as a latched relay does through a power cycle. The parameter `RETAIN_INIT` sets the value the register holds at time zero, which lets a bench start the cell from a retained closed or open state. All inputs are sampled on the rising clock edge, and the output comes straight from the state register.

Top module: `rsm_retentive_mem`

## Requirements
- R1: With `arm` high and no clear input high, a high level on any bit of `set_req` makes `q` read 1 after the next rising edge.
- R2: With `arm` high and no set input high, a high level on any bit of `clr_req` makes `q` read 0 after the next rising edge.
- R3: While `arm` is low, `set_req` and `clr_req` have no effect, and `q` keeps its value unless a manual strobe is high.
- R4: When `arm` is high and at least one set bit and at least one clear bit are high in the same cycle, `q` keeps its value.
- R5: A set or clear request that lasts a single cycle is enough to change `q`, and the new value holds in later idle cycles.
- R6: A high `man_set` makes `q` read 1 after the next edge, whatever `arm`, `set_req` and `clr_req` are doing, unless `man_clr` is also high.
- R7: A high `man_clr` makes `q` read 0 after the next edge, whatever `arm`, `set_req` and `clr_req` are doing. It wins over `man_set`.
- R8: The synchronous reset `rst` never clears the stored bit. In every cycle where `rst` is high, all other inputs are ignored and `q` holds.
- R9: At time zero, before any clock edge, `q` equals the parameter `RETAIN_INIT`, and it keeps that value through the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; freezes the cell and leaves the stored bit intact |
| arm | input | 1 | Shared qualifier; set and clear requests act only while it is high |
| set_req | input | N_SET | Logic set requests, ORed together |
| clr_req | input | N_CLR | Logic clear requests, ORed together |
| man_set | input | 1 | Manual strobe that forces the cell closed |
| man_clr | input | 1 | Manual strobe that forces the cell open; wins over man_set |
| q | output | 1 | Stored state |

## Verification
Retention is the hardest case to reach, because a plain reset normally erases any evidence of prior state. The bench builds the cell with `RETAIN_INIT` set to 1 and holds reset from time zero. It then drives clear requests and manual clears during that reset, so that a register that clears on reset, or one that listens to its inputs while reset is high, shows up as a 0. Later in the run it closes the cell again and pulses reset together with active clear requests. It then confirms that the closed state survives both the reset and the idle cycles after it.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    // Action chosen for the state register on a given edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } rsm_act_e;

    // Qualified logic-path requests after OR reduction and arming.
    typedef struct packed {
        logic set_hit;
        logic clr_hit;
    } rsm_req_t;

    // Manual strobe pair.
    typedef struct packed {
        logic force_set;
        logic force_clr;
    } rsm_man_t;

    // Logic-path resolution: conflicting requests leave the state alone.
    function automatic rsm_act_e logic_action(input rsm_req_t r);
        rsm_act_e a;
        unique case ({r.set_hit, r.clr_hit})
            2'b10:   a = ACT_SET;
            2'b01:   a = ACT_CLR;
            default: a = ACT_HOLD;
        endcase
        return a;
    endfunction

    // Manual-path resolution: a manual clear outranks a manual set.
    function automatic rsm_act_e manual_action(input rsm_man_t m);
        rsm_act_e a;
        if (m.force_clr)      a = ACT_CLR;
        else if (m.force_set) a = ACT_SET;
        else                  a = ACT_HOLD;
        return a;
    endfunction

    // Next value of the stored bit for a given action.
    function automatic logic apply_action(input rsm_act_e a, input logic cur);
        logic n;
        unique case (a)
            ACT_SET: n = 1'b1;
            ACT_CLR: n = 1'b0;
            default: n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rsm_gate.sv
module rsm_gate
    import rsm_pkg::*;
#(
    parameter int N_SET = 2,
    parameter int N_CLR = 2
) (
    input  logic             arm,
    input  logic [N_SET-1:0] set_req,
    input  logic [N_CLR-1:0] clr_req,
    output rsm_req_t         req
);

    localparam int S_LEN = N_SET + 1;
    localparam int C_LEN = N_CLR + 1;

    logic [S_LEN-1:0] s_chain;
    logic [C_LEN-1:0] c_chain;

    assign s_chain[0] = 1'b0;
    assign c_chain[0] = 1'b0;

    // OR the request lines one stage at a time.
    for (genvar i = 0; i < N_SET; i++) begin : g_set_or
        assign s_chain[i+1] = s_chain[i] | set_req[i];
    end

    for (genvar j = 0; j < N_CLR; j++) begin : g_clr_or
        assign c_chain[j+1] = c_chain[j] | clr_req[j];
    end

    // The shared arm line qualifies both paths.
    always_comb begin
        req.set_hit = arm & s_chain[S_LEN-1];
        req.clr_hit = arm & c_chain[C_LEN-1];
    end

    // R3: a disarmed gate passes nothing on.
    always_comb begin
        if (!arm) begin
            a_r3_disarmed_quiet: assert (req == '0);
        end
    end

endmodule

// File: rtl/rsm_arbiter.sv
module rsm_arbiter
    import rsm_pkg::*;
(
    input  rsm_req_t req,
    input  rsm_man_t man,
    output rsm_act_e act
);

    rsm_act_e logic_act;
    rsm_act_e man_act;

    always_comb begin
        logic_act = logic_action(req);
        man_act   = manual_action(man);
        // Any manual strobe overrides the logic path.
        if (man_act != ACT_HOLD) act = man_act;
        else                     act = logic_act;
    end

    // R7: a manual clear always produces a clear action.
    always_comb begin
        if (man.force_clr) begin
            a_r7_man_clr_wins: assert (act == ACT_CLR);
        end
    end

endmodule

// File: rtl/rsm_cell.sv
module rsm_cell
    import rsm_pkg::*;
#(
    parameter bit RETAIN_INIT = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  rsm_act_e act,
    output logic     q
);

    // The stored bit carries a power-up value and is never reset.
    logic state_q = RETAIN_INIT;

    always_ff @(posedge clk) begin
        if (!rst) begin
            state_q <= apply_action(act, state_q);
        end
    end

    assign q = state_q;

    // Checking state for R8: the value and reset level of the previous edge.
    logic chk_valid = 1'b0;
    logic chk_rst_d = 1'b0;
    logic chk_q_d   = RETAIN_INIT;

    always_ff @(posedge clk) begin
        chk_valid <= 1'b1;
        chk_rst_d <= rst;
        chk_q_d   <= state_q;
    end

    // R8: an edge taken with reset high leaves the bit unchanged.
    always_comb begin
        if (chk_valid && chk_rst_d) begin
            a_r8_reset_retains: assert (q == chk_q_d);
        end
    end

endmodule

// File: rtl/rsm_retentive_mem.sv
module rsm_retentive_mem
    import rsm_pkg::*;
#(
    parameter int N_SET       = 2,
    parameter int N_CLR       = 2,
    parameter bit RETAIN_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [N_SET-1:0] set_req,
    input  logic [N_CLR-1:0] clr_req,
    input  logic             man_set,
    input  logic             man_clr,
    output logic             q
);

    rsm_req_t req;
    rsm_man_t man;
    rsm_act_e act;

    assign man.force_set = man_set;
    assign man.force_clr = man_clr;

    rsm_gate #(
        .N_SET (N_SET),
        .N_CLR (N_CLR)
    ) u_gate (
        .arm     (arm),
        .set_req (set_req),
        .clr_req (clr_req),
        .req     (req)
    );

    rsm_arbiter u_arb (
        .req (req),
        .man (man),
        .act (act)
    );

    rsm_cell #(
        .RETAIN_INIT (RETAIN_INIT)
    ) u_cell (
        .clk (clk),
        .rst (rst),
        .act (act),
        .q   (q)
    );

    // R1: an armed set with no clear closes the cell.
    a_r1_set_closes: assert property (@(posedge clk) disable iff (rst)
        (arm && (|set_req) && !(|clr_req) && !man_clr) |=> q);

    // R2: an armed clear with no set opens the cell.
    a_r2_clr_opens: assert property (@(posedge clk) disable iff (rst)
        (arm && (|clr_req) && !(|set_req) && !man_set) |=> !q);

    // R3: disarmed and no strobes, the state holds.
    a_r3_disarmed_holds: assert property (@(posedge clk) disable iff (rst)
        (!arm && !man_set && !man_clr) |=> $stable(q));

    // R4: conflicting armed requests hold the state.
    a_r4_conflict_holds: assert property (@(posedge clk) disable iff (rst)
        (arm && (|set_req) && (|clr_req) && !man_set && !man_clr) |=> $stable(q));

    // R6: a lone manual set closes the cell.
    a_r6_man_set_closes: assert property (@(posedge clk) disable iff (rst)
        (man_set && !man_clr) |=> q);

    // R7: a manual clear opens the cell.
    a_r7_man_clr_opens: assert property (@(posedge clk) disable iff (rst)
        man_clr |=> !q);

endmodule

// File: tb/test_rsm_retentive_mem.sv
module test_rsm_retentive_mem;

    localparam int N_SET = 2;
    localparam int N_CLR = 2;

    typedef struct {
        logic  exp_q;
        string tag;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm = 1'b0;
    logic [N_SET-1:0] set_req = '0;
    logic [N_CLR-1:0] clr_req = '0;
    logic             man_set = 1'b0;
    logic             man_clr = 1'b0;
    logic             q;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    bit reported = 1'b0;
    logic model_q = 1'b1;

    exp_item_t sb[$];

    always #5 clk = ~clk;

    rsm_retentive_mem #(
        .N_SET       (N_SET),
        .N_CLR       (N_CLR),
        .RETAIN_INIT (1'b1)
    ) i_rsm_retentive_mem (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .set_req (set_req),
        .clr_req (clr_req),
        .man_set (man_set),
        .man_clr (man_clr),
        .q       (q)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected output.
    task automatic step(input logic r, input logic a,
                        input logic [N_SET-1:0] s, input logic [N_CLR-1:0] c,
                        input logic ms, input logic mc, input string tag);
        @(negedge clk);
        rst = r; arm = a; set_req = s; clr_req = c; man_set = ms; man_clr = mc;
        if (!r) begin
            if (mc)      model_q = 1'b0;
            else if (ms) model_q = 1'b1;
            else if (a) begin
                if ((|s) && !(|c))      model_q = 1'b1;
                else if ((|c) && !(|s)) model_q = 1'b0;
            end
        end
        sb.push_back('{exp_q: model_q, tag: tag});
    endtask

    // Monitor: compare after each edge has settled.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            checks++;
            if (q !== it.exp_q) begin
                failures++;
                $display("FAIL %s: q=%b expected=%b", it.tag, q, it.exp_q);
            end
        end
    end

    initial begin
        // R9: value at time zero, before any edge.
        #1;
        checks++;
        if (q !== 1'b1) begin
            failures++;
            $display("FAIL R9: q=%b expected=1 at time zero", q);
        end
        step(1, 0, 2'b00, 2'b00, 0, 0, "R9");
        // R8: during reset every input is ignored.
        step(1, 1, 2'b00, 2'b11, 0, 1, "R8");
        step(1, 1, 2'b01, 2'b10, 1, 1, "R8");
        step(0, 0, 2'b00, 2'b00, 0, 0, "R9");
        // R2 and R5: single-cycle clear on either bit.
        step(0, 1, 2'b00, 2'b10, 0, 0, "R2");
        step(0, 0, 2'b00, 2'b00, 0, 0, "R5");
        step(0, 1, 2'b01, 2'b00, 0, 0, "R1");
        step(0, 0, 2'b00, 2'b00, 0, 0, "R5");
        step(0, 1, 2'b00, 2'b01, 0, 0, "R2");
        step(0, 1, 2'b10, 2'b00, 0, 0, "R1");
        // R3: disarmed inputs ignored.
        step(0, 0, 2'b00, 2'b11, 0, 0, "R3");
        step(0, 1, 2'b00, 2'b01, 0, 0, "R2");
        step(0, 0, 2'b11, 2'b00, 0, 0, "R3");
        // R4: conflicting requests hold both states.
        step(0, 1, 2'b01, 2'b01, 0, 0, "R4");
        step(0, 1, 2'b11, 2'b00, 0, 0, "R1");
        step(0, 1, 2'b10, 2'b11, 0, 0, "R4");
        // R6 and R7: manual strobes.
        step(0, 1, 2'b00, 2'b01, 0, 0, "R2");
        step(0, 0, 2'b00, 2'b00, 1, 0, "R6");
        step(0, 1, 2'b00, 2'b11, 1, 0, "R6");
        step(0, 0, 2'b00, 2'b00, 0, 1, "R7");
        step(0, 1, 2'b11, 2'b00, 0, 1, "R7");
        step(0, 0, 2'b00, 2'b00, 1, 0, "R6");
        step(0, 0, 2'b00, 2'b00, 1, 1, "R7");
        // R8: closed state survives a later reset with active clears.
        step(0, 0, 2'b00, 2'b00, 1, 0, "R6");
        step(1, 1, 2'b00, 2'b11, 0, 1, "R8");
        step(1, 1, 2'b00, 2'b01, 0, 0, "R8");
        step(0, 0, 2'b00, 2'b00, 0, 0, "R8");
        step(0, 0, 2'b00, 2'b00, 0, 0, "R5");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        report();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
            $finish;
        end
    end

endmodule